// File: doc/BRIEF.md
# Shared Reset and Strobe Pin Filter

This block owns one active-low, open-drain pin that does two jobs. From outside, a long low level on the pin resets the serial bus controller it sits in. From inside, the controller pulls the same pin low for a short, fixed time to announce that a bus master addressed it and then ended the transfer without sending any data. The two uses are told apart only by how long the pin stays low. A run-length filter turns a low level into the internal reset only after a minimum number of consecutive low samples. The strobe is much shorter than that minimum, so it can never reset the device.

The pin input passes through a synchronizer of configurable depth. While the block drives its own strobe, and for as many cycles after as the synchronizer needs to drain, the filter treats the pin as high. The strobe is armed by a match on the block's own address or on the general call address; the address decoder lives elsewhere and reports a match as a one-cycle pulse. A data byte disarms the strobe, a STOP fires it if it is still armed, and the internal reset clears the armed state. The rest of the controller uses the internal reset to load its register defaults: the pending flag and bus-busy flag go to 1, all other status flags go to 0, and the own-address and vector registers go to 00h.

Top module: `rststb_pin`

## Requirements
- R1: `core_rst_o` rises once `pin_i` has been sampled low on RST_MIN (default 30) consecutive rising clock edges; it rises SYNC (default 2) edges after the edge that took the RST_MIN-th low sample.
- R2: A low run shorter than RST_MIN samples never raises `core_rst_o`; a single high sample restarts the count from zero, so two runs of 20 low samples split by one high sample do not reset.
- R3: While `pin_i` stays low past the threshold, `core_rst_o` stays high (the count saturates); after the first high sample it stays high for SYNC more edges and falls on the edge after that.
- R4: An address-match pulse followed by a STOP pulse, with no data-byte pulse between them, drives `strobe_pd_o` high for exactly STB_LEN (default 8) cycles, starting on the edge that samples the STOP.
- R5: A data-byte pulse after the address match disarms the strobe, so a following STOP produces no pulse; a new address match arms it again.
- R6: A STOP with no armed match produces no pulse; a STOP also disarms, so a second STOP after a strobe produces no pulse.
- R7: While `strobe_pd_o` is high and for SYNC cycles after it falls, the filter ignores the pin. The strobe never raises `core_rst_o`, and an external low run that starts right at the end of a strobe is counted only from its first sample outside that window.
- R8: `core_rst_o` clears the armed state: a match, then a reset, then a STOP gives no pulse.
- R9: A new match and STOP arriving while a strobe is in progress neither restart nor extend it, and leave the strobe disarmed.
- R10: After reset is released, `strobe_pd_o` is low and stays low without a new match and STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; must run for the reset filter to act |
| pin_i | input | 1 | Level read back from the shared pin, low active |
| addr_hit_i | input | 1 | One-cycle pulse: own address or general call address matched |
| data_byte_i | input | 1 | One-cycle pulse: a data byte followed the address |
| stop_i | input | 1 | One-cycle pulse: a STOP condition was seen on the bus |
| strobe_pd_o | output | 1 | Pull-down enable for the shared pin, high while strobing |
| core_rst_o | output | 1 | Internal reset to the controller, high active |

## Verification
A filter count that slipped by one shows up as `core_rst_o` rising or falling one edge early or late against a pin run whose length is known, so every reset check samples the exact edge on each side of the threshold and of the release. A wrong arming state appears as a pulse on `strobe_pd_o` one cycle after a STOP that should have been silent, or as a missing pulse after one that should fire, and a wrong pulse counter shows at the falling edge of the strobe. A mask that closes too early lets the strobe's own low level and the synchronizer tail feed the counter, which moves the rise of `core_rst_o` earlier in the run that follows a strobe.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

   typedef enum logic {
      ARM_IDLE = 1'b0,
      ARM_SET  = 1'b1
   } arm_e;

   // bits needed to hold the values 0 .. maxv
   function automatic int unsigned cnt_bits(input int unsigned maxv);
      int unsigned b;
      b = 1;
      while ((1 << b) <= maxv) b++;
      return b;
   endfunction

endpackage

// File: rtl/rsp_sync.sv
module rsp_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] sr_q;
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk) sr_q[0] <= d_i;
            end else begin : g_next
               always_ff @(posedge clk) sr_q[i] <= sr_q[i-1];
            end
         end
         assign q_o = sr_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rsp_filter.sv
module rsp_filter
   import rsp_pkg::*;
#(
   parameter int unsigned RST_MIN = 30
) (
   input  logic clk,
   input  logic pin_s_i,   // synchronized pin level
   input  logic mask_i,    // own strobe window: treat pin as high
   output logic rst_o
);

   localparam int unsigned CW = cnt_bits(RST_MIN);

   logic [CW-1:0] cnt_q;
   logic          low_seen;

   assign low_seen = !pin_s_i && !mask_i;

   // saturating run-length counter; any high or masked sample clears it
   always_ff @(posedge clk) begin
      if (!low_seen)
         cnt_q <= '0;
      else if (cnt_q != CW'(RST_MIN))
         cnt_q <= cnt_q + CW'(1);
   end

   assign rst_o = (cnt_q == CW'(RST_MIN));

   // R1: reset can only begin after a counted low sample
   a_r1_rise_needs_low: assert property (@(posedge clk) disable iff (mask_i)
      $rose(rst_o) |-> $past(low_seen));

   // R3: one high sample ends the reset on the next edge
   a_r3_release: assert property (@(posedge clk) disable iff (mask_i)
      (!pin_s_i == 1'b0) |=> !rst_o);

endmodule

// File: rtl/rsp_strobe.sv
module rsp_strobe
   import rsp_pkg::*;
#(
   parameter int unsigned STB_LEN = 8,
   parameter int unsigned SYNC    = 2
) (
   input  logic clk,
   input  logic rst_i,
   input  logic addr_i,
   input  logic data_i,
   input  logic stop_i,
   output logic pd_o,
   output logic mask_o
);

   localparam int unsigned LW = cnt_bits(STB_LEN);
   localparam int unsigned TW = cnt_bits(SYNC + 1);
   localparam int unsigned RW = LW + 1;

   arm_e          arm_q;
   logic          busy_q;
   logic [LW-1:0] len_q;
   logic          fire;

   assign fire = stop_i && (arm_q == ARM_SET) && !busy_q;

   always_ff @(posedge clk) begin
      if (rst_i) begin
         arm_q  <= ARM_IDLE;
         busy_q <= 1'b0;
         len_q  <= '0;
      end else begin
         if (addr_i)
            arm_q <= ARM_SET;
         else if (data_i || stop_i)
            arm_q <= ARM_IDLE;

         if (fire) begin
            busy_q <= 1'b1;
            len_q  <= LW'(STB_LEN - 1);
         end else if (busy_q) begin
            if (len_q == '0)
               busy_q <= 1'b0;
            else
               len_q <= len_q - LW'(1);
         end
      end
   end

   assign pd_o = busy_q;

   // mask covers the strobe plus the synchronizer drain time
   generate
      if (SYNC == 0) begin : g_nomask_tail
         assign mask_o = busy_q;
      end else begin : g_mask_tail
         logic [TW-1:0] tail_q;
         always_ff @(posedge clk) begin
            if (rst_i)
               tail_q <= '0;
            else if (busy_q)
               tail_q <= TW'(SYNC);
            else if (tail_q != '0)
               tail_q <= tail_q - TW'(1);
         end
         assign mask_o = busy_q || (tail_q != '0);
      end
   endgenerate

   // checker state: length of the current pull-down run
   logic [RW-1:0] run_q;
   always_ff @(posedge clk) begin
      if (rst_i)
         run_q <= '0;
      else if (pd_o)
         run_q <= run_q + RW'(1);
      else
         run_q <= '0;
   end

   // R4: pulse is never longer than STB_LEN
   a_r4_pulse_bound: assert property (@(posedge clk) disable iff (rst_i)
      pd_o |-> (run_q < RW'(STB_LEN)));

   // R4 and R9: every pulse ends after exactly STB_LEN cycles
   a_r4_pulse_len: assert property (@(posedge clk) disable iff (rst_i)
      $fell(pd_o) |-> (run_q == RW'(STB_LEN)));

   // R6: a STOP with nothing armed starts no pulse
   a_r6_no_idle_fire: assert property (@(posedge clk) disable iff (rst_i)
      (stop_i && (arm_q == ARM_IDLE) && !pd_o) |=> !pd_o);

   // R5: a data byte disarms the following STOP
   a_r5_data_disarms: assert property (@(posedge clk) disable iff (rst_i)
      (data_i && !addr_i && !pd_o) ##1 (stop_i && !pd_o) |=> !pd_o);

endmodule

// File: rtl/rststb_pin.sv
module rststb_pin #(
   parameter int unsigned RST_MIN = 30,
   parameter int unsigned STB_LEN = 8,
   parameter int unsigned SYNC    = 2
) (
   input  logic clk,
   input  logic pin_i,
   input  logic addr_hit_i,
   input  logic data_byte_i,
   input  logic stop_i,
   output logic strobe_pd_o,
   output logic core_rst_o
);

   initial begin
      assert (STB_LEN >= 1)
         else $error("rststb_pin: STB_LEN must be at least 1");
      assert (SYNC <= 4)
         else $error("rststb_pin: SYNC deeper than 4 is not supported");
      assert (RST_MIN > STB_LEN + SYNC + 1)
         else $error("rststb_pin: RST_MIN must exceed the strobe length plus sync depth");
   end

   logic pin_s;
   logic mask;

   rsp_sync #(.STAGES(SYNC)) u_sync (
      .clk (clk),
      .d_i (pin_i),
      .q_o (pin_s)
   );

   rsp_filter #(.RST_MIN(RST_MIN)) u_filter (
      .clk     (clk),
      .pin_s_i (pin_s),
      .mask_i  (mask),
      .rst_o   (core_rst_o)
   );

   rsp_strobe #(.STB_LEN(STB_LEN), .SYNC(SYNC)) u_strobe (
      .clk    (clk),
      .rst_i  (core_rst_o),
      .addr_i (addr_hit_i),
      .data_i (data_byte_i),
      .stop_i (stop_i),
      .pd_o   (strobe_pd_o),
      .mask_o (mask)
   );

   // R7: the block's own pull-down never turns into a reset
   a_r7_no_self_reset: assert property (@(posedge clk) disable iff (core_rst_o)
      strobe_pd_o |=> !core_rst_o);

endmodule

// File: tb/sim_rststb_pin.sv
module sim_rststb_pin;

   localparam int RST_MIN = 30;
   localparam int STB_LEN = 8;
   localparam int SYNC    = 2;

   logic clk = 1'b0;
   logic ext_low = 1'b0;
   logic addr_hit = 1'b0;
   logic data_byte = 1'b0;
   logic stop = 1'b0;
   logic pd;
   logic rst;
   logic pin_w;

   always #10 clk = ~clk;   // 50 MHz

   // open-drain pin: external pull-down or own strobe
   assign pin_w = (ext_low || pd) ? 1'b0 : 1'b1;

   rststb_pin #(.RST_MIN(RST_MIN), .STB_LEN(STB_LEN), .SYNC(SYNC)) u0 (
      .clk         (clk),
      .pin_i       (pin_w),
      .addr_hit_i  (addr_hit),
      .data_byte_i (data_byte),
      .stop_i      (stop),
      .strobe_pd_o (pd),
      .core_rst_o  (rst)
   );

   typedef struct {
      int    cyc;
      bit    is_rst;
      bit    val;
      string req;
   } exp_t;

   exp_t exp_q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: pop and compare items due in this cycle
   always @(negedge clk) begin
      for (int i = exp_q.size() - 1; i >= 0; i--) begin
         if (exp_q[i].cyc == cyc) begin
            logic act;
            act = exp_q[i].is_rst ? rst : pd;
            n_chk++;
            if (act !== exp_q[i].val) begin
               n_fail++;
               $display("FAIL %s cyc=%0d %s actual=%0b expected=%0b", exp_q[i].req, cyc,
                        exp_q[i].is_rst ? "core_rst_o" : "strobe_pd_o", act, exp_q[i].val);
            end
            exp_q.delete(i);
         end
      end
   end

   task automatic push(input int c, input bit is_rst, input bit v, input string req);
      exp_t e;
      e.cyc = c; e.is_rst = is_rst; e.val = v; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_addr();
      addr_hit = 1'b1; step(1); addr_hit = 1'b0;
   endtask

   task automatic pulse_data();
      data_byte = 1'b1; step(1); data_byte = 1'b0;
   endtask

   // drive STOP now; expect a strobe or silence
   task automatic pulse_stop(input bit fires, input string req);
      int c;
      c = cyc;
      if (fires) begin
         push(c + 1, 1'b0, 1'b1, req);
         push(c + STB_LEN, 1'b0, 1'b1, req);
         push(c + STB_LEN + 1, 1'b0, 1'b0, req);
      end else begin
         push(c + 1, 1'b0, 1'b0, req);
         push(c + 4, 1'b0, 1'b0, req);
      end
      stop = 1'b1; step(1); stop = 1'b0;
   endtask

   // hold the pin low for n samples, then release
   task automatic ext_reset(input int n, input string req);
      int c0;
      c0 = cyc;
      if (n >= RST_MIN) begin
         push(c0 + RST_MIN - 1 + SYNC, 1'b1, 1'b0, req);
         push(c0 + RST_MIN + SYNC, 1'b1, 1'b1, req);
         push(c0 + n + SYNC, 1'b1, 1'b1, req);
         push(c0 + n + SYNC + 1, 1'b1, 1'b0, req);
      end else begin
         push(c0 + n + SYNC, 1'b1, 1'b0, req);
         push(c0 + n + SYNC + 1, 1'b1, 1'b0, req);
      end
      ext_low = 1'b1; step(n); ext_low = 1'b0;
      step(SYNC + 3);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : driver
      int c;
      step(3);

      // power-up reset, held past the threshold (R1, R3)
      ext_reset(35, "R1/R3 long reset");
      // R10: quiet after reset
      push(cyc + 1, 1'b0, 1'b0, "R10 idle after reset");
      push(cyc + 6, 1'b0, 1'b0, "R10 idle after reset");
      step(8);

      // R2: one short of the threshold
      ext_reset(RST_MIN - 1, "R2 short run");
      // R2: two runs of 20 split by one high sample
      c = cyc;
      push(c + 41 + SYNC, 1'b1, 1'b0, "R2 split run");
      push(c + 42 + SYNC, 1'b1, 1'b0, "R2 split run");
      ext_low = 1'b1; step(20); ext_low = 1'b0; step(1); ext_low = 1'b1; step(20);
      ext_low = 1'b0; step(SYNC + 4);
      // R1 exactly at the threshold
      ext_reset(RST_MIN, "R1 exact threshold");
      step(4);

      // R4: match then STOP
      pulse_addr();
      c = cyc;
      pulse_stop(1'b1, "R4 strobe");
      push(c + STB_LEN + SYNC + 3, 1'b1, 1'b0, "R7 strobe does not reset");
      step(STB_LEN + SYNC + 6);

      // R5: data byte disarms, new match rearms
      pulse_addr(); pulse_data();
      pulse_stop(1'b0, "R5 disarmed by data");
      step(6);
      pulse_addr(); pulse_data(); pulse_addr();
      pulse_stop(1'b1, "R5 rearmed");
      step(STB_LEN + 4);

      // R6: STOP without match; second STOP after a strobe
      pulse_stop(1'b0, "R6 stop without match");
      step(6);
      pulse_addr();
      pulse_stop(1'b1, "R6 first stop");
      step(STB_LEN + 4);
      pulse_stop(1'b0, "R6 second stop");
      step(6);

      // R9: match and STOP during a strobe
      pulse_addr();
      c = cyc;
      pulse_stop(1'b1, "R9 first strobe");
      pulse_addr();
      stop = 1'b1; step(1); stop = 1'b0;
      push(c + STB_LEN + 1, 1'b0, 1'b0, "R9 not extended");
      push(c + STB_LEN + 6, 1'b0, 1'b0, "R9 not restarted");
      step(STB_LEN + 8);

      // R7: external low starting right as the strobe ends
      pulse_addr();
      c = cyc;
      stop = 1'b1; step(1); stop = 1'b0;
      push(c + STB_LEN + SYNC + 30, 1'b1, 1'b0, "R7 masked samples not counted");
      push(c + STB_LEN + SYNC + 31, 1'b1, 1'b1, "R7 count after mask");
      push(c + STB_LEN + 1 + 40 + SYNC, 1'b1, 1'b1, "R7 release");
      push(c + STB_LEN + 1 + 40 + SYNC + 1, 1'b1, 1'b0, "R7 release");
      step(STB_LEN);
      ext_low = 1'b1; step(40); ext_low = 1'b0;
      step(SYNC + 4);

      // R8: reset between match and STOP
      pulse_addr();
      step(2);
      ext_reset(RST_MIN + 2, "R8 reset");
      pulse_stop(1'b0, "R8 reset disarms");
      step(8);

      while (exp_q.size() != 0) step(1);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule